// File: doc/BRIEF.md
# Duplex Grid Timing with Dimming

This block produces the time-multiplexed drive for a two-grid, 30-segment vacuum fluorescent display run at half duty. A divider turns the core clock into a bit-time tick. A bit counter splits each frame into two equal slots, the first for grid 1 and the second for grid 2. In each slot the block shows one half of a 60-bit latched display word on the 30 segment lines. The grid outputs are active low, so they can drive external grid transistors directly.

How long each grid stays lit in its slot is the duty count. The park (night) input chooses its source. With park low the block runs at its day maximum. With park high it uses either an 11-bit digital dimming code or an externally supplied analog-derived duty code, each clamped to its own ceiling. A new duty is sampled only at a frame boundary, so a frame never mixes two brightness levels. The segment lines are dark during the first bit time of every slot and whenever the slot's grid is off, which keeps one grid's data from ghosting into the other. An active-low test input overrides everything and lights the whole display.

Top module: `vfd_duplex_scan`

## Requirements
- R1: One bit time is OSC_PER_BIT clock cycles (default 4). The bit counter advances exactly once per bit time.
- R2: A frame is FRAME_BITS bit times (default 4096). Bit times 0..2047 form the grid 1 slot and 2048..4095 form the grid 2 slot. The frame then wraps to 0.
- R3: Grid outputs are active low, with `grid_n[0]` for grid 1 and `grid_n[1]` for grid 2. A grid is driven low in its own slot while the slot position p (0..2047) satisfies p < duty. Otherwise it is high. Both grids are never low together outside test.
- R4: During the grid 1 slot, `seg[i]` shows `disp_bits[i]`. During the grid 2 slot, `seg[i]` shows `disp_bits[30+i]`.
- R5: Segments are 0 when the slot position is 0 and whenever the slot's grid is off. They are live for 1 <= p < duty.
- R6: With `park` low the duty is 2032.
- R7: With `park` high and `dim_digital` high the duty is min(`dim_code`, 2032).
- R8: With `park` high and `dim_digital` low the duty is min(`ana_duty`, 256).
- R9: The duty in use changes only on the bit-time tick that wraps the frame from 4095 to 0. It is taken from the inputs present at that tick.
- R10: While `test_n` is low, every segment is 1 and both grid outputs are 0, independent of timing.
- R11: After reset the counters are at zero and the duty is 2032. The first cycle after reset therefore shows `grid_n` = 2'b10 and all segments 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_bits | input | 60 | Latched display word; low 30 bits for grid 1, high 30 for grid 2 |
| park | input | 1 | High selects night (dimmed) duty, low selects day maximum |
| dim_digital | input | 1 | High selects the digital code, low the analog-derived code |
| dim_code | input | 11 | Digital dimming code, duty = code/2048 |
| ana_duty | input | 9 | Analog-derived duty count in bit times |
| test_n | input | 1 | Active-low lamp test |
| seg | output | 30 | Segment enables, active high |
| grid_n | output | 2 | Grid enables, active low |

## Verification
The bench goes after the duty clamps at both ceilings, with code 2047 against 2032 and analog 300 against 256. A design that compared against the raw code would light past bit time 2031 and close the guard gap before the grid change. Duty changes are written in the middle of a frame. A design that took them at once would change the grid width within that frame rather than at the wrap. The bench also checks segment blanking at slot position 0, the halving of the display word between the two grids, and the test override entered and left in mid-slot. A wrong half select would show grid 2's bits under grid 1, and a sticky test path would leave segments lit after `test_n` returns high.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
   typedef enum logic {SLOT_G1 = 1'b0, SLOT_G2 = 1'b1} slot_e;

   function automatic int unsigned clamp_u(input int unsigned v, input int unsigned lim);
      return (v > lim) ? lim : v;
   endfunction
endpackage

// File: rtl/vfd_bit_timer.sv
module vfd_bit_timer #(
   parameter int OSC_PER_BIT = 4,
   parameter int FRAME_BITS  = 4096,
   localparam int CNT_W = $clog2(FRAME_BITS),
   localparam int POS_W = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             tick,
   output logic             frame_end,
   output vfd_pkg::slot_e   slot,
   output logic [POS_W-1:0] pos
);
   logic [CNT_W-1:0] bit_q;

   generate
      if (OSC_PER_BIT == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(OSC_PER_BIT);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div_q <= '0;
            else if (tick) div_q <= '0;
            else           div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(OSC_PER_BIT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bit_q <= '0;
      else if (tick) bit_q <= bit_q + 1'b1;
   end

   assign frame_end = tick && (bit_q == CNT_W'(FRAME_BITS - 1));
   assign slot      = vfd_pkg::slot_e'(bit_q[CNT_W-1]);
   assign pos       = bit_q[POS_W-1:0];
endmodule

// File: rtl/vfd_duty_select.sv
module vfd_duty_select #(
   parameter int DIM_W      = 11,
   parameter int ANA_W      = 9,
   parameter int POS_W      = 11,
   parameter int DUTY_CAP   = 2032,
   parameter int ANALOG_CAP = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic             park,
   input  logic             dim_digital,
   input  logic [DIM_W-1:0] dim_code,
   input  logic [ANA_W-1:0] ana_duty,
   output logic [POS_W-1:0] duty_q
);
   logic [POS_W-1:0] duty_next;

   always_comb begin
      if (!park)
         duty_next = POS_W'(DUTY_CAP);
      else if (dim_digital)
         duty_next = POS_W'(vfd_pkg::clamp_u(int'(dim_code), DUTY_CAP));
      else
         duty_next = POS_W'(vfd_pkg::clamp_u(int'(ana_duty), ANALOG_CAP));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         duty_q <= POS_W'(DUTY_CAP);
      else if (frame_end) duty_q <= duty_next;
   end
endmodule

// File: rtl/vfd_drive_mux.sv
module vfd_drive_mux #(
   parameter int SEG_N  = 30,
   parameter int GRID_N = 2,
   parameter int POS_W  = 11
) (
   input  logic                    test_n,
   input  vfd_pkg::slot_e          slot,
   input  logic [POS_W-1:0]        pos,
   input  logic [POS_W-1:0]        duty,
   input  logic [GRID_N*SEG_N-1:0] disp_bits,
   output logic [SEG_N-1:0]        seg,
   output logic [GRID_N-1:0]       grid_n
);
   logic lit;
   logic seg_live;

   assign lit      = (pos < duty);
   assign seg_live = lit && (pos != '0);

   genvar g;
   generate
      for (g = 0; g < GRID_N; g++) begin : g_grid
         assign grid_n[g] = test_n ? ~(lit && (int'(slot) == g)) : 1'b0;
      end
   endgenerate

   always_comb begin
      if (!test_n)       seg = '1;
      else if (!seg_live) seg = '0;
      else               seg = disp_bits[int'(slot)*SEG_N +: SEG_N];
   end
endmodule

// File: rtl/vfd_duplex_scan.sv
module vfd_duplex_scan #(
   parameter int OSC_PER_BIT = 4,
   parameter int FRAME_BITS  = 4096,
   parameter int SEG_N       = 30,
   parameter int DIM_W       = 11,
   parameter int ANA_W       = 9,
   parameter int DUTY_CAP    = 2032,
   parameter int ANALOG_CAP  = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*SEG_N-1:0]   disp_bits,
   input  logic                 park,
   input  logic                 dim_digital,
   input  logic [DIM_W-1:0]     dim_code,
   input  logic [ANA_W-1:0]     ana_duty,
   input  logic                 test_n,
   output logic [SEG_N-1:0]     seg,
   output logic [1:0]           grid_n
);
   localparam int CNT_W = $clog2(FRAME_BITS);
   localparam int POS_W = CNT_W - 1;
   localparam int HALF  = FRAME_BITS / 2;

   generate
      if ((1 << CNT_W) != FRAME_BITS) begin : g_bad_frame
         $error("FRAME_BITS must be a power of two");
      end
      if (DUTY_CAP >= HALF || ANALOG_CAP > DUTY_CAP) begin : g_bad_cap
         $error("duty caps must stay below the slot length");
      end
      if (OSC_PER_BIT < 1) begin : g_bad_div
         $error("OSC_PER_BIT must be at least 1");
      end
   endgenerate

   logic             tick;
   logic             frame_end;
   vfd_pkg::slot_e   slot;
   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] duty_q;

   vfd_bit_timer #(.OSC_PER_BIT(OSC_PER_BIT), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .frame_end(frame_end),
      .slot(slot), .pos(pos)
   );

   vfd_duty_select #(.DIM_W(DIM_W), .ANA_W(ANA_W), .POS_W(POS_W),
                     .DUTY_CAP(DUTY_CAP), .ANALOG_CAP(ANALOG_CAP)) u_duty (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .park(park),
      .dim_digital(dim_digital), .dim_code(dim_code), .ana_duty(ana_duty),
      .duty_q(duty_q)
   );

   vfd_drive_mux #(.SEG_N(SEG_N), .GRID_N(2), .POS_W(POS_W)) u_mux (
      .test_n(test_n), .slot(slot), .pos(pos), .duty(duty_q),
      .disp_bits(disp_bits), .seg(seg), .grid_n(grid_n)
   );
endmodule

// File: rtl/vfd_duplex_scan_chk.sv
module vfd_duplex_scan_chk #(
   parameter int SEG_N    = 30,
   parameter int POS_W    = 11,
   parameter int DUTY_CAP = 2032
) (
   input logic             clk,
   input logic             rst_n,
   input logic             test_n,
   input logic [SEG_N-1:0] seg,
   input logic [1:0]       grid_n,
   input logic             frame_end,
   input logic [POS_W-1:0] duty_q
);
   a_r3_one_grid: assert property (@(posedge clk) disable iff (!rst_n)
      test_n |-> $countones(~grid_n) <= 1);

   a_r5_dark_without_grid: assert property (@(posedge clk) disable iff (!rst_n)
      (test_n && grid_n == 2'b11) |-> seg == '0);

   a_r10_lamp_test: assert property (@(posedge clk) disable iff (!rst_n)
      !test_n |-> (seg == '1 && grid_n == 2'b00));

   a_r9_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(duty_q));

   a_r6_duty_capped: assert property (@(posedge clk) disable iff (!rst_n)
      int'(duty_q) <= DUTY_CAP);
endmodule

bind vfd_duplex_scan vfd_duplex_scan_chk #(.SEG_N(SEG_N), .POS_W(POS_W), .DUTY_CAP(DUTY_CAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .test_n(test_n), .seg(seg), .grid_n(grid_n),
   .frame_end(frame_end), .duty_q(duty_q)
);

// File: tb/vfd_duplex_scan_tb_top.sv
module vfd_duplex_scan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [59:0] disp_bits = 60'h0A5_C3F0_1E2D_4B69;
   logic        park = 1'b0;
   logic        dim_digital = 1'b1;
   logic [10:0] dim_code = 11'd0;
   logic [8:0]  ana_duty = 9'd0;
   logic        test_n = 1'b1;
   logic [29:0] seg;
   logic [1:0]  grid_n;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   longint mdl_cnt = 0;
   int     mdl_duty = 2032;

   always #5 clk = ~clk;

   vfd_duplex_scan dut_i (
      .clk(clk), .rst_n(rst_n), .disp_bits(disp_bits), .park(park),
      .dim_digital(dim_digital), .dim_code(dim_code), .ana_duty(ana_duty),
      .test_n(test_n), .seg(seg), .grid_n(grid_n)
   );

   function automatic int pick_duty();
      int v;
      if (!park) return 2032;                     // R6
      if (dim_digital) begin
         v = int'(dim_code);
         return (v > 2032) ? 2032 : v;            // R7
      end
      v = int'(ana_duty);
      return (v > 256) ? 256 : v;                 // R8
   endfunction

   // Reference model: R1 (4 clocks per bit time), R2 (4096-bit frame), R9 (wrap-only update)
   always @(posedge clk) begin
      if (rst_n) begin
         if ((mdl_cnt % 4) == 3 && ((mdl_cnt / 4) % 4096) == 4095)
            mdl_duty = pick_duty();
         mdl_cnt = mdl_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int bt, pos, half;
         logic [29:0] e_seg;
         logic [1:0]  e_grid;
         bit on;
         bt   = int'((mdl_cnt / 4) % 4096);
         half = bt / 2048;
         pos  = bt % 2048;
         on   = pos < mdl_duty;
         if (!test_n) begin                       // R10
            e_seg  = '1;
            e_grid = 2'b00;
         end else begin
            e_grid = 2'b11;
            if (on) e_grid[half] = 1'b0;          // R3
            e_seg = (on && pos != 0) ? (half == 1 ? disp_bits[59:30] : disp_bits[29:0]) : '0; // R4 R5
         end
         compared++;
         if (seg !== e_seg || grid_n !== e_grid) begin
            mismatched++;
            $display("FAIL %s cyc=%0d grid_n=%b/%b seg=%h/%h (actual/expected)",
                     !test_n ? "R10" : (grid_n !== e_grid ? "R3" : "R4"),
                     mdl_cnt, grid_n, e_grid, seg, e_seg);
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(4);
      rst_n = 1'b1;
      // R11: first compare at count 0 expects grid_n=10, seg=0
      cycles(8000);
      park = 1'b1; dim_code = 11'd100;            // R7 mid-frame: applies at next wrap (R9)
      cycles(16384);
      dim_code = 11'd2047;                        // R7 clamp to 2032
      disp_bits = 60'hFFF_0000_FFFF_0001;
      cycles(16384);
      dim_code = 11'd0;                           // zero duty: all dark
      cycles(16384);
      dim_digital = 1'b0; ana_duty = 9'd300;      // R8 clamp to 256
      cycles(16384);
      ana_duty = 9'd50;                           // R8 below cap
      cycles(16384);
      park = 1'b0;                                // R6 back to day maximum
      cycles(9000);
      test_n = 1'b0;                              // R10 enter mid-slot
      cycles(200);
      test_n = 1'b1;
      cycles(16384);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog expired R1 actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule